// File: doc/BRIEF.md
# Branch Target Cache with Direction Prediction

This block sits beside the instruction fetch stage and predicts, in the same cycle as the fetch address appears, whether the fetch should jump and where it should go. It is a small direct-mapped table that the fetch PC indexes. Each entry holds the tag of a branch address, its target, the kind of branch (conditional, unconditional jump or return) and a saturating direction counter. When the lookup hits and the entry predicts taken, the block raises a redirect with the stored target. The fetch stage can then load the target on the next edge with no bubble.

The execute stage reports each resolved branch through a resolve port: its PC, its kind, whether it was taken and its computed target. The block compares that outcome with the prediction the table holds at that moment and flags a mismatch. It then allocates or refreshes the entry for that PC. Two strobes, one for a memory barrier and one for a synchronizing branch, flush the whole table in one cycle. This also happens when the strobe arrives in the same cycle as the resolve of the branch just before it.

Top module: `branch_target_cache`

## Requirements
- R1: A resolve whose kind is conditional (1), jump (2) or return (3) writes its entry at the index of its PC. The entry is marked valid and takes the resolved target, the kind and the PC's tag. The counter is set to weakly taken (2'b10) unless the entry already held this conditional branch.
- R2: When the fetch PC hits a valid entry that predicts taken, pred_valid_o is high in that same cycle and pred_target_o carries the stored target.
- R3: Entries of kind jump or return always predict taken, whatever their counter holds.
- R4: A conditional entry predicts taken when its counter's upper bit is set. The counter is encoded 00 strongly not-taken, 01 weakly not-taken, 10 weakly taken and 11 strongly taken. Each conditional resolve that hits the entry steps the counter up on taken and down on not-taken, saturating at 11 and 00.
- R5: A high level on clr_barrier_i or clr_sync_i leaves every entry invalid from the next cycle on.
- R6: In a cycle where either clear strobe is high, pred_valid_o is low.
- R7: The table has 16 entries indexed by PC bits [5:2]. PC bits [31:6] form the tag, so a fetch PC that shares an index with an entry but differs in its tag misses.
- R8: During a valid resolve of kind 1 to 3, mispredict_o is high in the same cycle if the table's current prediction for that PC differs from the resolved direction. A miss counts as a not-taken prediction. mispredict_o is also high if both are taken but the stored target differs from the resolved target.
- R9: A resolve of kind 0 (not an immediate branch or return) neither allocates an entry nor raises mispredict_o.
- R10: When a clear strobe and a resolve occur in the same cycle, the clear wins and the resolved branch is not left in the table.
- R11: The active-low asynchronous reset leaves all entries invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_pc_i | input | 32 | Current fetch address |
| res_valid_i | input | 1 | Resolve port carries a branch this cycle |
| res_pc_i | input | 32 | Address of the resolved branch |
| res_kind_i | input | 2 | 0 other, 1 conditional, 2 jump, 3 return |
| res_taken_i | input | 1 | Resolved direction |
| res_target_i | input | 32 | Resolved target address |
| clr_barrier_i | input | 1 | Memory barrier executed: flush table |
| clr_sync_i | input | 1 | Synchronizing branch executed: flush table |
| pred_valid_o | output | 1 | Redirect fetch to pred_target_o |
| pred_target_o | output | 32 | Predicted target address |
| mispredict_o | output | 1 | Resolved outcome differs from the table's prediction |

## Verification
The assertions assume that res_kind_i and res_taken_i are stable whenever res_valid_i is high. They also assume that a jump or return resolved at a given PC always carries the same target unless the test changes it on purpose. A third assumption is that clear strobes are single-cycle pulses from retiring instructions. The stimulus drives all inputs at the falling edge and keeps every resolve tied to one address per kind. It changes a target only in one directed vector that checks the target-mismatch report.

// File: rtl/btc_pkg.sv
package btc_pkg;
  typedef enum logic [1:0] {
    BK_NONE = 2'd0,
    BK_COND = 2'd1,
    BK_JUMP = 2'd2,
    BK_RET  = 2'd3
  } btc_kind_e;
endpackage

// File: rtl/btc_ctr_next.sv
module btc_ctr_next #(
  parameter int CTR_W = 2
) (
  input  logic [CTR_W-1:0] ctr_i,
  input  logic             taken_i,
  output logic [CTR_W-1:0] ctr_o
);
  localparam logic [CTR_W-1:0] CTR_MAX = '1;
  localparam logic [CTR_W-1:0] CTR_MIN = '0;

  always_comb begin
    ctr_o = ctr_i;
    if (taken_i && ctr_i != CTR_MAX)       ctr_o = ctr_i + 1'b1;
    else if (!taken_i && ctr_i != CTR_MIN) ctr_o = ctr_i - 1'b1;
  end
endmodule

// File: rtl/btc_match.sv
module btc_match
  import btc_pkg::*;
#(
  parameter int TAG_W = 26,
  parameter int CTR_W = 2
) (
  input  logic             ent_valid_i,
  input  logic [TAG_W-1:0] ent_tag_i,
  input  btc_kind_e        ent_kind_i,
  input  logic [CTR_W-1:0] ent_ctr_i,
  input  logic [TAG_W-1:0] look_tag_i,
  output logic             hit_o,
  output logic             taken_o
);
  always_comb begin
    hit_o   = ent_valid_i && (ent_tag_i == look_tag_i);
    // jumps and returns ignore the counter
    taken_o = hit_o && ((ent_kind_i != BK_COND) || ent_ctr_i[CTR_W-1]);
  end
endmodule

// File: rtl/btc_array.sv
module btc_array
  import btc_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 26,
  parameter int PC_W  = 32,
  parameter int CTR_W = 2,
  parameter int N_RD  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [PC_W-1:0]  wr_tgt_i,
  input  btc_kind_e        wr_kind_i,
  input  logic [CTR_W-1:0] wr_ctr_i,
  input  logic [IDX_W-1:0] rd_idx_i   [N_RD],
  output logic             rd_valid_o [N_RD],
  output logic [TAG_W-1:0] rd_tag_o   [N_RD],
  output logic [PC_W-1:0]  rd_tgt_o   [N_RD],
  output btc_kind_e        rd_kind_o  [N_RD],
  output logic [CTR_W-1:0] rd_ctr_o   [N_RD]
);
  localparam int N_ENT = 1 << IDX_W;

  logic [N_ENT-1:0] valid_q;
  logic [TAG_W-1:0] tag_q  [N_ENT];
  logic [PC_W-1:0]  tgt_q  [N_ENT];
  btc_kind_e        kind_q [N_ENT];
  logic [CTR_W-1:0] ctr_q  [N_ENT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int e = 0; e < N_ENT; e++) begin
        tag_q[e]  <= '0;
        tgt_q[e]  <= '0;
        kind_q[e] <= BK_NONE;
        ctr_q[e]  <= '0;
      end
    end else if (clr_i) begin
      valid_q <= '0;  // flush wins over a same-cycle write
    end else if (wr_en_i) begin
      valid_q[wr_idx_i] <= 1'b1;
      tag_q[wr_idx_i]   <= wr_tag_i;
      tgt_q[wr_idx_i]   <= wr_tgt_i;
      kind_q[wr_idx_i]  <= wr_kind_i;
      ctr_q[wr_idx_i]   <= wr_ctr_i;
    end
  end

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    assign rd_valid_o[p] = valid_q[rd_idx_i[p]];
    assign rd_tag_o[p]   = tag_q[rd_idx_i[p]];
    assign rd_tgt_o[p]   = tgt_q[rd_idx_i[p]];
    assign rd_kind_o[p]  = kind_q[rd_idx_i[p]];
    assign rd_ctr_o[p]   = ctr_q[rd_idx_i[p]];
  end

  // R5 / R10: any clear empties the table on the next edge
  a_r5_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (valid_q == '0));

  // R1: a write outside a clear leaves its entry valid
  a_r1_alloc_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !clr_i) |=> valid_q[$past(wr_idx_i)]);
endmodule

// File: rtl/branch_target_cache.sv
module branch_target_cache
  import btc_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  parameter int CTR_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] fetch_pc_i,
  input  logic            res_valid_i,
  input  logic [PC_W-1:0] res_pc_i,
  input  logic [1:0]      res_kind_i,
  input  logic            res_taken_i,
  input  logic [PC_W-1:0] res_target_i,
  input  logic            clr_barrier_i,
  input  logic            clr_sync_i,
  output logic            pred_valid_o,
  output logic [PC_W-1:0] pred_target_o,
  output logic            mispredict_o
);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_LO + IDX_W - 1;
  localparam int TAG_W  = PC_W - IDX_W - IDX_LO;
  localparam int N_RD   = 2;
  localparam int P_F    = 0;  // fetch lookup port
  localparam int P_R    = 1;  // resolve lookup port
  localparam logic [CTR_W-1:0] CTR_WEAK_T = CTR_W'(1) << (CTR_W - 1);

  logic [IDX_W-1:0] rd_idx   [N_RD];
  logic [TAG_W-1:0] look_tag [N_RD];
  logic             rd_valid [N_RD];
  logic [TAG_W-1:0] rd_tag   [N_RD];
  logic [PC_W-1:0]  rd_tgt   [N_RD];
  btc_kind_e        rd_kind  [N_RD];
  logic [CTR_W-1:0] rd_ctr   [N_RD];
  logic             hit      [N_RD];
  logic             taken    [N_RD];

  btc_kind_e        res_kind;
  logic             clr;
  logic             res_imm;
  logic             same_cond;
  logic [CTR_W-1:0] ctr_step;
  logic [CTR_W-1:0] wr_ctr;

  assign res_kind = btc_kind_e'(res_kind_i);
  assign clr      = clr_barrier_i | clr_sync_i;
  assign res_imm  = res_valid_i && (res_kind != BK_NONE);

  assign rd_idx[P_F]   = fetch_pc_i[IDX_HI:IDX_LO];
  assign rd_idx[P_R]   = res_pc_i[IDX_HI:IDX_LO];
  assign look_tag[P_F] = fetch_pc_i[PC_W-1:IDX_HI+1];
  assign look_tag[P_R] = res_pc_i[PC_W-1:IDX_HI+1];

  btc_array #(
    .IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W), .CTR_W(CTR_W), .N_RD(N_RD)
  ) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .wr_en_i    (res_imm),
    .wr_idx_i   (rd_idx[P_R]),
    .wr_tag_i   (look_tag[P_R]),
    .wr_tgt_i   (res_target_i),
    .wr_kind_i  (res_kind),
    .wr_ctr_i   (wr_ctr),
    .rd_idx_i   (rd_idx),
    .rd_valid_o (rd_valid),
    .rd_tag_o   (rd_tag),
    .rd_tgt_o   (rd_tgt),
    .rd_kind_o  (rd_kind),
    .rd_ctr_o   (rd_ctr)
  );

  for (genvar p = 0; p < N_RD; p++) begin : g_match
    btc_match #(.TAG_W(TAG_W), .CTR_W(CTR_W)) u_match (
      .ent_valid_i (rd_valid[p]),
      .ent_tag_i   (rd_tag[p]),
      .ent_kind_i  (rd_kind[p]),
      .ent_ctr_i   (rd_ctr[p]),
      .look_tag_i  (look_tag[p]),
      .hit_o       (hit[p]),
      .taken_o     (taken[p])
    );
  end

  btc_ctr_next #(.CTR_W(CTR_W)) u_ctr (
    .ctr_i   (rd_ctr[P_R]),
    .taken_i (res_taken_i),
    .ctr_o   (ctr_step)
  );

  // counter history is kept only while the entry still holds this conditional branch
  assign same_cond = hit[P_R] && (rd_kind[P_R] == BK_COND) && (res_kind == BK_COND);
  assign wr_ctr    = same_cond ? ctr_step : CTR_WEAK_T;

  assign pred_valid_o  = taken[P_F] && !clr;
  assign pred_target_o = rd_tgt[P_F];
  assign mispredict_o  = res_imm &&
                         ((taken[P_R] != res_taken_i) ||
                          (res_taken_i && (rd_tgt[P_R] != res_target_i)));

  // R6: no redirect while a flush is in progress
  a_r6_clear_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |-> !pred_valid_o);

  // R9: non-immediate resolves never report a mismatch
  a_r9_none_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && res_kind == BK_NONE) |-> !mispredict_o);

  // R8: fetch-side redirect agrees with resolve-side check for the same jump
  a_r8_ports_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && res_kind == BK_JUMP && res_taken_i && !clr &&
     res_pc_i == fetch_pc_i && pred_valid_o && pred_target_o == res_target_i)
    |-> !mispredict_o);

  // R5: the cycle after a flush nothing redirects
  a_r5_no_hit_after_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> !pred_valid_o);
endmodule

// File: tb/sim_branch_target_cache.sv
module sim_branch_target_cache;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] fetch_pc_i = '0;
  logic        res_valid_i = 1'b0;
  logic [31:0] res_pc_i = '0;
  logic [1:0]  res_kind_i = '0;
  logic        res_taken_i = 1'b0;
  logic [31:0] res_target_i = '0;
  logic        clr_barrier_i = 1'b0;
  logic        clr_sync_i = 1'b0;
  logic        pred_valid_o;
  logic [31:0] pred_target_o;
  logic        mispredict_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  branch_target_cache u0 (.*);

  typedef struct packed {
    logic [31:0] fpc;
    logic        rv;
    logic [31:0] rpc;
    logic [1:0]  rk;
    logic        rt;
    logic [31:0] rtgt;
    logic [1:0]  clr;   // [1] sync, [0] barrier
    logic        ep;
    logic [31:0] etgt;
    logic        em;
    logic [7:0]  req;
  } vec_t;

  localparam logic [31:0] PA = 32'h100, PB = 32'h104, PC = 32'h148;
  localparam logic [31:0] PD = 32'h500, PE = 32'h10C;
  localparam int NV = 24;

  localparam vec_t VECS [NV] = '{
    '{PA, 1'b0, 32'h0, 2'd0, 1'b0, 32'h0,   2'b00, 1'b0, 32'h0,   1'b0, 8'd1},  // R1 empty
    '{PA, 1'b1, PA,    2'd2, 1'b1, 32'h200, 2'b00, 1'b0, 32'h0,   1'b1, 8'd8},  // R8 miss vs taken
    '{PA, 1'b0, 32'h0, 2'd0, 1'b0, 32'h0,   2'b00, 1'b1, 32'h200, 1'b0, 8'd2},  // R2 redirect
    '{PB, 1'b1, PB,    2'd1, 1'b0, 32'h180, 2'b00, 1'b0, 32'h0,   1'b0, 8'd1},  // R1 alloc cond
    '{PB, 1'b1, PB,    2'd1, 1'b0, 32'h180, 2'b00, 1'b1, 32'h180, 1'b1, 8'd4},  // R4 weak taken
    '{PB, 1'b1, PB,    2'd1, 1'b1, 32'h180, 2'b00, 1'b0, 32'h0,   1'b1, 8'd4},  // R4 01
    '{PB, 1'b1, PB,    2'd1, 1'b1, 32'h180, 2'b00, 1'b1, 32'h180, 1'b0, 8'd4},  // R4 10
    '{PB, 1'b1, PB,    2'd1, 1'b1, 32'h180, 2'b00, 1'b1, 32'h180, 1'b0, 8'd4},  // R4 11 sat
    '{PB, 1'b1, PB,    2'd1, 1'b0, 32'h180, 2'b00, 1'b1, 32'h180, 1'b1, 8'd4},  // R4 11->10
    '{PB, 1'b0, 32'h0, 2'd0, 1'b0, 32'h0,   2'b00, 1'b1, 32'h180, 1'b0, 8'd4},  // R4 hysteresis
    '{PD, 1'b0, 32'h0, 2'd0, 1'b0, 32'h0,   2'b00, 1'b0, 32'h0,   1'b0, 8'd7},  // R7 alias miss
    '{PC, 1'b1, PC,    2'd3, 1'b1, 32'h400, 2'b00, 1'b0, 32'h0,   1'b1, 8'd1},  // R1 return
    '{PC, 1'b0, 32'h0, 2'd0, 1'b0, 32'h0,   2'b00, 1'b1, 32'h400, 1'b0, 8'd3},  // R3 return taken
    '{PA, 1'b1, PA,    2'd2, 1'b1, 32'h300, 2'b00, 1'b1, 32'h200, 1'b1, 8'd8},  // R8 target diff
    '{PA, 1'b0, 32'h0, 2'd0, 1'b0, 32'h0,   2'b00, 1'b1, 32'h300, 1'b0, 8'd1},  // R1 refresh
    '{PE, 1'b1, PE,    2'd0, 1'b1, 32'h700, 2'b00, 1'b0, 32'h0,   1'b0, 8'd9},  // R9 ignored
    '{PE, 1'b0, 32'h0, 2'd0, 1'b0, 32'h0,   2'b00, 1'b0, 32'h0,   1'b0, 8'd9},  // R9 no alloc
    '{PA, 1'b0, 32'h0, 2'd0, 1'b0, 32'h0,   2'b10, 1'b0, 32'h0,   1'b0, 8'd6},  // R6 sync clear
    '{PA, 1'b0, 32'h0, 2'd0, 1'b0, 32'h0,   2'b00, 1'b0, 32'h0,   1'b0, 8'd5},  // R5 flushed
    '{PC, 1'b0, 32'h0, 2'd0, 1'b0, 32'h0,   2'b00, 1'b0, 32'h0,   1'b0, 8'd5},  // R5 flushed
    '{PB, 1'b0, 32'h0, 2'd0, 1'b0, 32'h0,   2'b00, 1'b0, 32'h0,   1'b0, 8'd5},  // R5 flushed
    '{PA, 1'b1, PA,    2'd2, 1'b1, 32'h200, 2'b00, 1'b0, 32'h0,   1'b1, 8'd1},  // R1 realloc
    '{PA, 1'b1, PA,    2'd2, 1'b1, 32'h200, 2'b01, 1'b0, 32'h0,   1'b0, 8'd10}, // R10 barrier+resolve
    '{PA, 1'b0, 32'h0, 2'd0, 1'b0, 32'h0,   2'b00, 1'b0, 32'h0,   1'b0, 8'd10}  // R10 clear won
  };

  task automatic check(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    res_valid_i = 1'b0; res_pc_i = '0; res_kind_i = '0; res_taken_i = 1'b0;
    res_target_i = '0; clr_barrier_i = 1'b0; clr_sync_i = 1'b0;
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk_i);
    fetch_pc_i = v.fpc; res_valid_i = v.rv; res_pc_i = v.rpc; res_kind_i = v.rk;
    res_taken_i = v.rt; res_target_i = v.rtgt;
    clr_sync_i = v.clr[1]; clr_barrier_i = v.clr[0];
    #2;
    check(pred_valid_o == v.ep, int'(v.req), "pred_valid", 32'(pred_valid_o), 32'(v.ep));
    if (v.ep) check(pred_target_o == v.etgt, int'(v.req), "pred_target", pred_target_o, v.etgt);
    check(mispredict_o == v.em, int'(v.req), "mispredict", 32'(mispredict_o), 32'(v.em));
  endtask

  initial begin : watchdog
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired: actual running expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R11: after reset no PC redirects
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      fetch_pc_i = 32'h100 + 32'(i * 4);
      #2;
      check(pred_valid_o == 1'b0, 11, "reset pred_valid", 32'(pred_valid_o), 32'd0);
      check(mispredict_o == 1'b0, 11, "reset mispredict", 32'(mispredict_o), 32'd0);
    end

    for (int k = 0; k < NV; k++) apply(VECS[k]);

    // R11: reset mid-run drops a live entry
    apply('{PC, 1'b1, PC, 2'd3, 1'b1, 32'h400, 2'b00, 1'b0, 32'h0, 1'b1, 8'd11});
    @(negedge clk_i);
    idle_inputs();
    fetch_pc_i = PC;
    #2;
    check(pred_valid_o == 1'b1, 11, "pre-reset hit", 32'(pred_valid_o), 32'd1);
    rst_ni = 1'b0;
    #1;
    check(pred_valid_o == 1'b0, 11, "post-reset miss", 32'(pred_valid_o), 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R5: barrier strobe alone flushes a return entry
    apply('{PC, 1'b1, PC, 2'd3, 1'b1, 32'h400, 2'b00, 1'b0, 32'h0, 1'b1, 8'd5});
    apply('{PC, 1'b0, 32'h0, 2'd0, 1'b0, 32'h0, 2'b01, 1'b0, 32'h0, 1'b0, 8'd6});
    apply('{PC, 1'b0, 32'h0, 2'd0, 1'b0, 32'h0, 2'b00, 1'b0, 32'h0, 1'b0, 8'd5});

    // R3: jump replacing a cond entry at same PC predicts taken from a fresh state
    apply('{PB, 1'b1, PB, 2'd1, 1'b0, 32'h180, 2'b00, 1'b0, 32'h0, 1'b0, 8'd1});
    apply('{PB, 1'b1, PB, 2'd1, 1'b0, 32'h180, 2'b00, 1'b1, 32'h180, 1'b1, 8'd4});
    apply('{PB, 1'b1, PB, 2'd2, 1'b1, 32'h180, 2'b00, 1'b0, 32'h0, 1'b1, 8'd3});
    apply('{PB, 1'b0, 32'h0, 2'd0, 1'b0, 32'h0, 2'b00, 1'b1, 32'h180, 1'b0, 8'd3});

    @(negedge clk_i);
    idle_inputs();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule